// File: doc/BRIEF.md
# NAND Command Sequence Engine

This block turns one operation request into the ordered byte traffic an 8-bit NAND flash device expects. A request carries the kind of operation (block erase, page program or page read), up to five address bytes with the number of them to send, a setup count that sets the width of each strobe pulse, and a byte count for the data phase. The engine drives the command-latch and address-latch enables, the write and read strobes and the data bus. It then waits for the device's ready/busy line to return high, sets a sticky completion bit and pulses an interrupt.

Program data is pulled one byte at a time from a source that advances on a take pulse. Page read data is fetched with read-strobe pulses after the device becomes ready and is handed out one byte per valid pulse. The ready/busy line is asynchronous and passes through a two-flop synchronizer before edge detection. A request that arrives while an operation is still running is dropped and flagged.

Top module: `nand_seq_engine`

## Requirements
- R1: While reset is high and after it is released, the write and read strobes are high, both latch enables are low, the bus is not driven, and busy, done_stat, irq, err_stat, wr_take and rd_valid are low.
- R2: An erase request (req_op 0) produces command byte 0x60, then the address bytes, then command byte 0xD0, with no data bytes.
- R3: A program request (req_op 1) produces command 0x80, then the address bytes, then req_len data bytes taken from wr_byte, then command 0x10. wr_take pulses once per data byte, and wr_byte must advance after each pulse.
- R4: A read request (req_op 2 or 3) produces command 0x00, then the address bytes, then command 0x30. After the device becomes ready, it issues req_len read-strobe pulses, and each captured bus byte is presented on rd_data with a one-cycle rd_valid, in order.
- R5: The engine sends req_addr_cycles address bytes, with 0 treated as 1 and values above 5 treated as 5. Byte k is req_addr[8k+7:8k], lowest byte first. Command bytes carry cle=1, ale=0, address bytes carry cle=0, ale=1, and data bytes carry both low.
- R6: Every write or read strobe pulse stays low for exactly req_setup+1 clocks and is followed by at least one high clock. The latch enables stay stable for the whole low time.
- R7: After the final command, done_stat stays low while ready/busy is low. It is set 2 to 4 clocks after ready/busy rises, together with exactly one single-cycle irq pulse. It stays set until the next accepted request.
- R8: A request while busy is high is ignored: the running byte sequence is unchanged, and err_stat is set on the next clock. err_stat is cleared when a request is next accepted.
- R9: busy rises the clock after a request is accepted in idle and falls when the operation ends. While busy is low, no strobe or latch enable is active.
- R10: nand_dq_oe is high whenever the write strobe is low and low whenever the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operation request strobe |
| req_op | input | 2 | 0 erase, 1 program, 2/3 read |
| req_addr | input | 40 | Address bytes, byte 0 sent first |
| req_addr_cycles | input | 3 | Number of address bytes (clamped 1..5) |
| req_setup | input | 4 | Strobe low time minus one, in clocks |
| req_len | input | 12 | Data bytes to write or read |
| wr_byte | input | 8 | Current program data byte |
| wr_take | output | 1 | Current program byte consumed |
| busy | output | 1 | Operation in progress |
| done_stat | output | 1 | Sticky completion bit |
| irq | output | 1 | One-cycle completion interrupt |
| err_stat | output | 1 | Request rejected while busy |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | rd_data valid this cycle |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Bus data driven to the device |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_in | input | 8 | Bus data from the device |
| nand_rb | input | 1 | Ready/busy from device, low while busy |

## Verification
The properties assume a device that pulls ready/busy low only after a confirm command and releases it once, with no glitch, while the engine waits. They also assume wr_byte changes only after a take pulse. The stimulus models the device this way: it pulls the line low two clocks after seeing a confirm byte, holds it for a random busy time, and serves read bytes only on falling read strobes. Random requests vary the operation, address count (including out-of-range values), setup count, data length and address bytes. Directed cases cover zero-length transfers, the widest setup, five address bytes and a request issued mid-operation.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

    localparam logic [7:0] CMD_ERASE_SETUP = 8'h60;
    localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
    localparam logic [7:0] CMD_PROG_SETUP  = 8'h80;
    localparam logic [7:0] CMD_PROG_GO     = 8'h10;
    localparam logic [7:0] CMD_READ_SETUP  = 8'h00;
    localparam logic [7:0] CMD_READ_GO     = 8'h30;

    typedef enum logic [1:0] {
        OP_ERASE = 2'd0,
        OP_PROG  = 2'd1,
        OP_READ  = 2'd2,
        OP_READX = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CMD1, ST_ADDR, ST_WDATA, ST_CMD2, ST_WAIT, ST_RDATA
    } st_e;

    typedef enum logic [1:0] {
        BUS_NONE, BUS_WR, BUS_RD
    } bus_e;

    typedef struct packed {
        logic [7:0] first;
        logic [7:0] second;
    } cmd_pair_t;

    function automatic cmd_pair_t cmds_for(op_e op);
        cmd_pair_t c;
        case (op)
            OP_ERASE: begin c.first = CMD_ERASE_SETUP; c.second = CMD_ERASE_GO; end
            OP_PROG:  begin c.first = CMD_PROG_SETUP;  c.second = CMD_PROG_GO;  end
            default:  begin c.first = CMD_READ_SETUP;  c.second = CMD_READ_GO;  end
        endcase
        return c;
    endfunction

    function automatic logic is_read(op_e op);
        return (op == OP_READ) || (op == OP_READX);
    endfunction

endpackage

// File: rtl/nseq_rb_sync.sv
module nseq_rb_sync (
    input  logic clk,
    input  logic rst,
    input  logic rb_async,
    output logic rb_rise
);
    logic s1, s2, s3;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= rb_async;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign rb_rise = s2 & ~s3;
endmodule

// File: rtl/nseq_strobe.sv
module nseq_strobe
    import nseq_pkg::*;
#(
    parameter int SETUP_W = 4,
    localparam int CW = SETUP_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  bus_e               mode,
    input  logic [SETUP_W-1:0] setup,
    output logic               we_n,
    output logic               re_n,
    output logic               sample,
    output logic               last
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic          active;
    logic          low;

    assign lim    = {1'b0, setup} + CW'(1);
    assign active = (mode != BUS_NONE);
    assign low    = active && (cnt < lim);
    assign last   = active && (cnt == lim);
    assign sample = (mode == BUS_RD) && (cnt == {1'b0, setup});
    assign we_n   = !(low && (mode == BUS_WR));
    assign re_n   = !(low && (mode == BUS_RD));

    always_ff @(posedge clk) begin
        if (rst || !active || last) cnt <= '0;
        else                        cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/nand_seq_engine.sv
module nand_seq_engine
    import nseq_pkg::*;
#(
    parameter int ADDR_MAX = 5,
    parameter int SETUP_W  = 4,
    parameter int LEN_W    = 12,
    localparam int AW      = 8 * ADDR_MAX,
    localparam int NCYC_W  = $clog2(ADDR_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [AW-1:0]     req_addr,
    input  logic [NCYC_W-1:0] req_addr_cycles,
    input  logic [SETUP_W-1:0] req_setup,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [7:0]        wr_byte,
    output logic              wr_take,
    output logic              busy,
    output logic              done_stat,
    output logic              irq,
    output logic              err_stat,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [7:0]        nand_dq_out,
    output logic              nand_dq_oe,
    input  logic [7:0]        nand_dq_in,
    input  logic              nand_rb
);
    st_e               st;
    op_e               op_q;
    logic [AW-1:0]     addr_q;
    logic [NCYC_W-1:0] ncyc_q;
    logic [SETUP_W-1:0] setup_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  idx;
    logic [NCYC_W-1:0] ncyc_in;
    cmd_pair_t         cmds;
    bus_e              mode;
    logic              bus_last, bus_sample, rb_rise;
    logic              last_addr, last_data;

    always_comb begin
        if (req_addr_cycles == '0)
            ncyc_in = NCYC_W'(1);
        else if (req_addr_cycles > NCYC_W'(ADDR_MAX))
            ncyc_in = NCYC_W'(ADDR_MAX);
        else
            ncyc_in = req_addr_cycles;
    end

    assign cmds = cmds_for(op_q);

    always_comb begin
        case (st)
            ST_CMD1, ST_ADDR, ST_WDATA, ST_CMD2: mode = BUS_WR;
            ST_RDATA:                            mode = BUS_RD;
            default:                             mode = BUS_NONE;
        endcase
    end

    nseq_strobe #(.SETUP_W(SETUP_W)) u_strobe (
        .clk(clk), .rst(rst), .mode(mode), .setup(setup_q),
        .we_n(nand_we_n), .re_n(nand_re_n), .sample(bus_sample), .last(bus_last)
    );

    nseq_rb_sync u_rb (
        .clk(clk), .rst(rst), .rb_async(nand_rb), .rb_rise(rb_rise)
    );

    assign last_addr = (idx == LEN_W'(ncyc_q) - LEN_W'(1));
    assign last_data = (idx == len_q - LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            op_q      <= OP_ERASE;
            addr_q    <= '0;
            ncyc_q    <= NCYC_W'(1);
            setup_q   <= '0;
            len_q     <= '0;
            idx       <= '0;
            done_stat <= 1'b0;
            irq       <= 1'b0;
            err_stat  <= 1'b0;
            rd_data   <= '0;
            rd_valid  <= 1'b0;
        end else begin
            irq      <= 1'b0;
            rd_valid <= 1'b0;
            if (req_valid && st != ST_IDLE)
                err_stat <= 1'b1;
            case (st)
                ST_IDLE: if (req_valid) begin
                    op_q      <= op_e'(req_op);
                    addr_q    <= req_addr;
                    ncyc_q    <= ncyc_in;
                    setup_q   <= req_setup;
                    len_q     <= req_len;
                    idx       <= '0;
                    done_stat <= 1'b0;
                    err_stat  <= 1'b0;
                    st        <= ST_CMD1;
                end
                ST_CMD1: if (bus_last) st <= ST_ADDR;
                ST_ADDR: if (bus_last) begin
                    if (last_addr) begin
                        idx <= '0;
                        st  <= (op_q == OP_PROG && len_q != '0) ? ST_WDATA : ST_CMD2;
                    end else begin
                        idx <= idx + LEN_W'(1);
                    end
                end
                ST_WDATA: if (bus_last) begin
                    if (last_data) st <= ST_CMD2;
                    idx <= last_data ? '0 : idx + LEN_W'(1);
                end
                ST_CMD2: if (bus_last) st <= ST_WAIT;
                ST_WAIT: if (rb_rise) begin
                    done_stat <= 1'b1;
                    irq       <= 1'b1;
                    idx       <= '0;
                    st        <= (is_read(op_q) && len_q != '0) ? ST_RDATA : ST_IDLE;
                end
                ST_RDATA: begin
                    if (bus_sample) begin
                        rd_data  <= nand_dq_in;
                        rd_valid <= 1'b1;
                    end
                    if (bus_last) begin
                        if (last_data) st <= ST_IDLE;
                        idx <= idx + LEN_W'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        case (st)
            ST_CMD1:  nand_dq_out = cmds.first;
            ST_CMD2:  nand_dq_out = cmds.second;
            ST_ADDR:  nand_dq_out = 8'(addr_q >> {idx, 3'b000});
            ST_WDATA: nand_dq_out = wr_byte;
            default:  nand_dq_out = 8'h00;
        endcase
    end

    assign nand_cle   = (st == ST_CMD1) || (st == ST_CMD2);
    assign nand_ale   = (st == ST_ADDR);
    assign nand_dq_oe = (mode == BUS_WR);
    assign wr_take    = (st == ST_WDATA) && bus_last;
    assign busy       = (st != ST_IDLE);
endmodule

// File: rtl/nseq_checker.sv
module nseq_checker (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic busy,
    input logic done_stat,
    input logic irq,
    input logic err_stat,
    input logic nand_cle,
    input logic nand_ale,
    input logic nand_we_n,
    input logic nand_re_n,
    input logic nand_dq_oe
);
    assert_latch_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(nand_cle && nand_ale));

    assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(!nand_we_n && !nand_re_n));

    assert_latch_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (!nand_we_n && $past(!nand_we_n)) |-> ($stable(nand_cle) && $stable(nand_ale)));

    assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    assert_irq_done_R7: assert property (@(posedge clk) disable iff (rst)
        irq |-> done_stat);

    assert_reject_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && busy) |=> err_stat);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (nand_we_n && nand_re_n && !nand_cle && !nand_ale));

    assert_oe_dir_R10: assert property (@(posedge clk) disable iff (rst)
        (!nand_we_n |-> nand_dq_oe) and (!nand_re_n |-> !nand_dq_oe));
endmodule

bind nand_seq_engine nseq_checker u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .busy(busy),
    .done_stat(done_stat), .irq(irq), .err_stat(err_stat),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_dq_oe(nand_dq_oe)
);

// File: tb/sim_nand_seq_engine.sv
module sim_nand_seq_engine;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0;
    logic [39:0] req_addr = '0;
    logic [2:0]  req_addr_cycles = 3'd1;
    logic [3:0]  req_setup = '0;
    logic [11:0] req_len = '0;
    logic [7:0]  wr_byte = '0;
    logic        wr_take, busy, done_stat, irq, err_stat, rd_valid;
    logic [7:0]  rd_data, nand_dq_out;
    logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_in = '0;
    logic        nand_rb = 1'b1;

    nand_seq_engine u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_addr_cycles(req_addr_cycles),
        .req_setup(req_setup), .req_len(req_len), .wr_byte(wr_byte),
        .wr_take(wr_take), .busy(busy), .done_stat(done_stat), .irq(irq),
        .err_stat(err_stat), .rd_data(rd_data), .rd_valid(rd_valid),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
        .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
    );

    always #(CLK_P/2) clk = ~clk;

    int n_chk = 0, n_bad = 0;
    logic [1:0] lk [64];
    logic [7:0] lb [64];
    int lcnt = 0;
    logic [7:0] wr_mem [64];
    logic [7:0] rd_mem [64];
    logic [7:0] rgot [64];
    int widx = 0, ridx = 0, rcnt = 0;
    int cur_setup = 0, busy_len = 5;
    bit conf_pend = 0;
    int wl = 0, rl = 0, wbad = 0, obad = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_sim();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    // device model: bus write log, confirm detection
    initial forever begin
        @(posedge nand_we_n);
        if (!rst && lcnt < 64) begin
            lk[lcnt] = nand_cle ? 2'd1 : (nand_ale ? 2'd2 : 2'd3);
            lb[lcnt] = nand_dq_out;
            lcnt++;
            if (nand_cle && (nand_dq_out == 8'hD0 || nand_dq_out == 8'h10 || nand_dq_out == 8'h30))
                conf_pend = 1;
        end
    end

    // device model: ready/busy
    initial forever begin
        @(posedge clk);
        if (conf_pend) begin
            conf_pend = 0;
            repeat (2) @(posedge clk);
            nand_rb = 1'b0;
            repeat (busy_len) @(posedge clk);
            nand_rb = 1'b1;
        end
    end

    // device model: read data on falling read strobe
    initial forever begin
        @(negedge nand_re_n);
        #1;
        nand_dq_in = rd_mem[ridx % 64];
        ridx++;
    end

    // monitors sampled away from the active edge
    initial forever begin
        @(negedge clk);
        if (!rst) begin
            if (!nand_we_n) wl++;
            else if (wl > 0) begin if (wl != cur_setup + 1) wbad++; wl = 0; end
            if (!nand_re_n) rl++;
            else if (rl > 0) begin if (rl != cur_setup + 1) wbad++; rl = 0; end
            if (!nand_we_n && !nand_dq_oe) obad++;
            if (!nand_re_n && nand_dq_oe) obad++;
            if (rd_valid && rcnt < 64) begin rgot[rcnt] = rd_data; rcnt++; end
            if (wr_take) begin widx++; wr_byte = wr_mem[widx % 64]; end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_sim();
    end

    task automatic run_op(input int op, input logic [39:0] addr, input int ncyc,
                          input int setup, input int len, input bit inject);
        logic [1:0] ek [64];
        logic [7:0] eb [64];
        int en = 0, nc, mism, cyc, rise_t, done_t, irqs;
        bit rb_low_seen, early;
        string tg;
        tg = (op == 0) ? "R2" : (op == 1) ? "R3" : "R4";
        nc = (ncyc == 0) ? 1 : (ncyc > 5 ? 5 : ncyc);
        for (int i = 0; i < 64; i++) begin
            wr_mem[i] = 8'($urandom);
            rd_mem[i] = 8'($urandom);
        end
        ek[en] = 2'd1; eb[en] = (op == 0) ? 8'h60 : (op == 1) ? 8'h80 : 8'h00; en++;
        for (int k = 0; k < nc; k++) begin ek[en] = 2'd2; eb[en] = addr[8*k +: 8]; en++; end
        if (op == 1) for (int k = 0; k < len; k++) begin ek[en] = 2'd3; eb[en] = wr_mem[k]; en++; end
        ek[en] = 2'd1; eb[en] = (op == 0) ? 8'hD0 : (op == 1) ? 8'h10 : 8'h30; en++;

        @(negedge clk);
        lcnt = 0; widx = 0; ridx = 0; rcnt = 0; wbad = 0; obad = 0;
        cur_setup = setup; busy_len = 3 + int'($urandom % 18);
        wr_byte = wr_mem[0];
        req_valid = 1; req_op = 2'(op); req_addr = addr;
        req_addr_cycles = 3'(ncyc); req_setup = 4'(setup); req_len = 12'(len);
        @(negedge clk);
        req_valid = 0;
        chk(busy == 1, "R9 busy after accept", int'(busy), 1);
        chk(err_stat == 0, "R8 err cleared on accept", int'(err_stat), 0);

        cyc = 0; rise_t = -1; done_t = -1; irqs = 0; rb_low_seen = 0; early = 0;
        while (busy && cyc < 5000) begin
            if (inject && cyc == 3) begin
                req_valid = 1; req_op = 2'd0; req_addr = ~addr; req_addr_cycles = 3'd1;
            end
            @(negedge clk);
            if (inject && cyc == 3) begin
                req_valid = 0;
                chk(err_stat == 1, "R8 reject flag", int'(err_stat), 1);
            end
            cyc++;
            if (nand_rb == 0) rb_low_seen = 1;
            if (nand_rb == 0 && done_stat) early = 1;
            if (rb_low_seen && nand_rb == 1 && rise_t < 0) rise_t = cyc;
            if (done_stat && done_t < 0) done_t = cyc;
            if (irq) irqs++;
        end
        repeat (2) @(negedge clk);

        chk(!busy && nand_we_n && nand_re_n && !nand_cle && !nand_ale,
            "R9 idle after op", int'(busy), 0);
        chk(lcnt == en, {tg, " R5 bus byte count"}, lcnt, en);
        mism = 0;
        for (int i = 0; i < en && i < lcnt; i++)
            if (lk[i] != ek[i] || lb[i] != eb[i]) mism++;
        chk(mism == 0, {tg, " R5 byte sequence"}, mism, 0);
        chk(wbad == 0, "R6 strobe width", wbad, 0);
        chk(obad == 0, "R10 bus direction", obad, 0);
        chk(!early, "R7 done before ready", int'(early), 0);
        chk(done_t - rise_t >= 2 && done_t - rise_t <= 4, "R7 done latency", done_t - rise_t, 3);
        chk(irqs == 1, "R7 irq pulses", irqs, 1);
        chk(done_stat == 1, "R7 done sticky", int'(done_stat), 1);
        if (op == 1) chk(widx == len, "R3 take count", widx, len);
        if (op >= 2) begin
            chk(rcnt == len, "R4 read count", rcnt, len);
            mism = 0;
            for (int i = 0; i < rcnt && i < len; i++) if (rgot[i] != rd_mem[i]) mism++;
            chk(mism == 0, "R4 read data", mism, 0);
        end
        if (inject) chk(err_stat == 1, "R8 flag holds", int'(err_stat), 1);
    endtask

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        chk(nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe,
            "R1 bus in reset", int'(nand_we_n), 1);
        rst = 0;
        @(negedge clk);
        chk(!busy && !done_stat && !irq && !err_stat && !wr_take && !rd_valid,
            "R1 flags after reset", int'(busy), 0);

        run_op(0, 40'h00_00_12_34_56, 3, 0, 0, 0);   // R2 erase
        run_op(1, 40'h55_44_33_22_11, 5, 2, 4, 0);   // R3 program
        run_op(1, 40'h00_00_00_AB_CD, 2, 1, 0, 0);   // R3 zero length
        run_op(2, 40'h01_02_03_04_05, 5, 15, 3, 0);  // R4 widest setup
        run_op(3, 40'h00_00_00_00_7E, 0, 0, 2, 0);   // R5 zero cycles clamp
        run_op(0, 40'hFE_DC_BA_98_76, 7, 1, 0, 0);   // R5 over-range clamp
        run_op(1, 40'h00_00_09_08_07, 3, 1, 3, 1);   // R8 reject mid-op
        run_op(2, 40'h00_00_00_10_20, 2, 0, 0, 0);   // R4 read, no data
        for (int i = 0; i < 30; i++)
            run_op(int'($urandom % 4), {$urandom, 8'($urandom)}, int'($urandom % 8),
                   int'($urandom % 5), int'($urandom % 7), (i % 7) == 3);
        finish_sim();
    end
endmodule